// File: doc/BRIEF.md
# Prioritised Interrupt Resolver

This block gathers eight interrupt lines, remembers which of them have raised a request, and decides which one the processor should take next. A request is latched on the rising edge of its line and is forgotten if the line falls before delivery. Among the pending requests that the enable mask lets through, the lowest index wins. A request is held back while an interrupt of equal or higher priority is still being serviced.

Delivery uses a valid/ready pair. `irq_valid` is high in every cycle in which a request can be delivered, and `irq_vector` carries the vector for the current winner in that same cycle. The processor takes the interrupt by raising `irq_ready`. A cycle with both high is the acknowledge. In that cycle the winner's pending bit is dropped and, unless automatic end-of-interrupt is on, its in-service bit is set. Back-pressure is unbounded: a request that is not yet accepted stays pending with `irq_valid` high. The winner, and with it the vector, can still change before acceptance if a higher-priority request arrives or the mask changes. `irq_ready` has no effect while `irq_valid` is low.

Two end-of-interrupt commands exist. The general command retires the highest-priority in-service bit. The targeted command retires the bit named by a 3-bit level. Special mask mode makes disabled in-service bits stop blocking, so lower-priority lines can be serviced while a masked handler runs. The pending and in-service registers are exported for read-back.

Top module: `irq_resolver`

## Requirements
- R1: A synchronous active-high `rst` clears the pending bits, the in-service bits and the stored line levels, so that after reset `pending_bits`, `service_bits` and `irq_valid` are all zero.
- R2: A line that was low in the previous cycle and is high now sets its pending bit (bit i for line i) one clock later. A line held high sets its bit again only after it has gone low and risen once more.
- R3: A line sampled low clears its pending bit at that clock edge.
- R4: The candidate is the lowest-indexed bit of `pending_bits & irq_enable` (a 1 in `irq_enable` enables a line; index 0 has the highest priority). A masked pending request stays pending and is not delivered.
- R5: While `irq_valid` is high, `irq_vector` equals `vec_base` bitwise ORed with the 3-bit candidate index placed in bits 2:0.
- R6: `irq_valid` stays high as long as a deliverable request exists, whether or not `irq_ready` is high. An acknowledge (`irq_valid` and `irq_ready` both high) clears the candidate's pending bit at that edge. `irq_ready` while `irq_valid` is low changes nothing.
- R7: On an acknowledge with `auto_eoi` low, the candidate's in-service bit is set at that edge. With `auto_eoi` high, no in-service bit is set.
- R8: If any blocking in-service bit has an index at or below the candidate index, `irq_valid` is low. A candidate with a lower index than every blocking in-service bit is delivered.
- R9: With `special_mask` low, every in-service bit blocks. With `special_mask` high, only in-service bits whose `irq_enable` bit is 1 block.
- R10: A one-cycle `eoi_nonspec` pulse clears the lowest-indexed set in-service bit.
- R11: A one-cycle `eoi_spec` pulse clears in-service bit `eoi_level`. If both pulses occur in the same cycle, both clears apply to the old in-service value, and a bit set by a same-cycle acknowledge still ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 8 | Interrupt request lines, edge-captured |
| irq_enable | input | 8 | Per-line enable, 1 = enabled |
| vec_base | input | 8 | Vector base ORed with the winning index |
| auto_eoi | input | 1 | 1 = acknowledge does not set an in-service bit |
| special_mask | input | 1 | 1 = only enabled in-service bits block |
| eoi_nonspec | input | 1 | Pulse: retire the highest-priority in-service bit |
| eoi_spec | input | 1 | Pulse: retire in-service bit `eoi_level` |
| eoi_level | input | 3 | Level selected by `eoi_spec` |
| irq_valid | output | 1 | A deliverable request exists |
| irq_ready | input | 1 | Processor accepts the offered interrupt |
| irq_vector | output | 8 | Vector of the offered interrupt |
| pending_bits | output | 8 | Pending request register |
| service_bits | output | 8 | In-service register |

## Verification
The bench builds the block with its defaults: eight lines and an 8-bit vector. At this size every one of the 256 request patterns can be swept under several enable masks. A long pseudo-random run then covers the interleavings of line toggles, acknowledges, both end-of-interrupt commands and mode flips against an arithmetic model of the pending and in-service registers. Short directed sequences pin the literal outcomes of held lines, masked requests, blocking, and special mask mode.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  // Outcome of one priority evaluation
  typedef enum logic [1:0] {
    PICK_IDLE    = 2'd0,  // nothing pending at all
    PICK_MASKED  = 2'd1,  // pending, but every pending line is disabled
    PICK_BLOCKED = 2'd2,  // candidate held back by in-service state
    PICK_READY   = 2'd3   // candidate offered to the processor
  } pick_status_e;

  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_VEC_W   = 8;

endpackage

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  onehot,   // lowest set bit isolated
  output logic [IW-1:0] idx,      // index of that bit
  output logic          any,      // at least one bit set
  output logic [N-1:0]  upto      // bits at or below the lowest set bit
);

  logic [N-1:0] seen;  // seen[i] = |vec[i:0]

  assign seen[0]   = vec[0];
  assign onehot[0] = vec[0];

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign seen[i]   = seen[i-1] | vec[i];
    assign onehot[i] = vec[i] & ~seen[i-1];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end

  assign any  = seen[N-1];
  assign upto = ~seen | onehot;

endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] take,      // one-hot bit being delivered, or zero
  output logic [N-1:0] pending
);

  logic [N-1:0] level_q;
  logic [N-1:0] rise;

  assign rise = lines & ~level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      pending <= '0;
    end else begin
      level_q <= lines;
      pending <= (pending | rise) & lines & ~take;
    end
  end

  // R2: every fresh rising edge is recorded
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & $past(lines & ~level_q)) == $past(lines & ~level_q)));

  // R3: a low line never leaves a request behind
  p_drop_clears_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & ~$past(lines)) == '0));

  // R2: a bit can only appear after a rising edge
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(lines & ~level_q)) == '0));

endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick
  import irq_res_pkg::*;
#(
  parameter int N  = 8,
  parameter int VW = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pending,
  input  logic [N-1:0]  enable,
  input  logic [N-1:0]  in_service,
  input  logic          special,
  input  logic [VW-1:0] base,
  output logic          offer,
  output logic [N-1:0]  win_onehot,
  output logic [IW-1:0] win_idx,
  output logic [VW-1:0] vector,
  output pick_status_e  status
);

  logic [N-1:0] live;
  logic [N-1:0] blockers;
  logic [N-1:0] at_or_above;
  logic         have_cand;
  logic         blocked;

  assign live = pending & enable;

  irq_lowest_find #(.N(N), .IW(IW)) i_cand (
    .vec    (live),
    .onehot (win_onehot),
    .idx    (win_idx),
    .any    (have_cand),
    .upto   (at_or_above)
  );

  // special mask mode: disabled in-service levels stop blocking
  assign blockers = special ? (in_service & enable) : in_service;
  assign blocked  = |(blockers & at_or_above);

  always_comb begin
    if (pending == '0)      status = PICK_IDLE;
    else if (!have_cand)    status = PICK_MASKED;
    else if (blocked)       status = PICK_BLOCKED;
    else                    status = PICK_READY;
  end

  assign offer  = have_cand & ~blocked;
  assign vector = base | VW'(win_idx);

endmodule

// File: rtl/irq_service_track.sv
module irq_service_track #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [N-1:0]  accept_onehot,
  input  logic          auto_eoi,
  input  logic          eoi_nonspec,
  input  logic          eoi_spec,
  input  logic [IW-1:0] eoi_level,
  output logic [N-1:0]  in_service
);

  logic [N-1:0] lowest;
  logic [N-1:0] clr_general;
  logic [N-1:0] clr_target;
  logic [N-1:0] set_bits;

  assign lowest      = in_service & (~in_service + N'(1));
  assign clr_general = eoi_nonspec ? lowest : '0;
  assign clr_target  = eoi_spec ? (N'(1) << eoi_level) : '0;
  assign set_bits    = (accept && !auto_eoi) ? accept_onehot : '0;

  always_ff @(posedge clk) begin
    if (rst) in_service <= '0;
    else     in_service <= (in_service & ~(clr_general | clr_target)) | set_bits;
  end

  // R7: an accepted interrupt is marked in service without auto EOI
  p_mark_service_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && !auto_eoi) |=> ((in_service & $past(accept_onehot)) != '0));

  // R7: with auto EOI, no new in-service bit appears
  p_auto_eoi_r7: assert property (@(posedge clk) disable iff (rst)
    (auto_eoi || !accept) |=> ((in_service & ~$past(in_service)) == '0));

  // R10: a lone general EOI retires exactly one bit
  p_general_eoi_r10: assert property (@(posedge clk) disable iff (rst)
    (eoi_nonspec && !eoi_spec && !accept && (in_service != '0)) |=>
      ($countones(in_service) + 1 == $countones($past(in_service))));

  // R11: targeted EOI clears its level
  p_target_eoi_r11: assert property (@(posedge clk) disable iff (rst)
    (eoi_spec && !accept) |=> !in_service[$past(eoi_level)]);

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int N  = int'(DEF_LINES),
  parameter int VW = int'(DEF_VEC_W),
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_lines,
  input  logic [N-1:0]  irq_enable,
  input  logic [VW-1:0] vec_base,
  input  logic          auto_eoi,
  input  logic          special_mask,
  input  logic          eoi_nonspec,
  input  logic          eoi_spec,
  input  logic [IW-1:0] eoi_level,
  output logic          irq_valid,
  input  logic          irq_ready,
  output logic [VW-1:0] irq_vector,
  output logic [N-1:0]  pending_bits,
  output logic [N-1:0]  service_bits
);

  logic          accept;
  logic [N-1:0]  win_onehot;
  logic [N-1:0]  take;
  logic [IW-1:0] win_idx;
  pick_status_e  status;

  assign accept = irq_valid & irq_ready;
  assign take   = accept ? win_onehot : '0;

  irq_edge_capture #(.N(N)) i_edge (
    .clk     (clk),
    .rst     (rst),
    .lines   (irq_lines),
    .take    (take),
    .pending (pending_bits)
  );

  irq_priority_pick #(.N(N), .VW(VW), .IW(IW)) i_pick (
    .pending    (pending_bits),
    .enable     (irq_enable),
    .in_service (service_bits),
    .special    (special_mask),
    .base       (vec_base),
    .offer      (irq_valid),
    .win_onehot (win_onehot),
    .win_idx    (win_idx),
    .vector     (irq_vector),
    .status     (status)
  );

  irq_service_track #(.N(N), .IW(IW)) i_svc (
    .clk           (clk),
    .rst           (rst),
    .accept        (accept),
    .accept_onehot (win_onehot),
    .auto_eoi      (auto_eoi),
    .eoi_nonspec   (eoi_nonspec),
    .eoi_spec      (eoi_spec),
    .eoi_level     (eoi_level),
    .in_service    (service_bits)
  );

  // R4: the offered line is pending and enabled
  p_offer_pending_r4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (pending_bits[win_idx] && irq_enable[win_idx]));

  // R5: upper vector bits come from the base
  p_vector_base_r5: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ((irq_vector & ~VW'(N-1)) == (vec_base & ~VW'(N-1))));

  // R6: acknowledged request leaves the pending register
  p_accept_clears_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> !pending_bits[$past(win_idx)]);

  // R8: blocking requires something in service
  p_block_needs_service_r8: assert property (@(posedge clk) disable iff (rst)
    (status == PICK_BLOCKED) |-> (service_bits != '0));

  // R1: nothing offered while nothing is pending
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (pending_bits == '0) |-> !irq_valid);

endmodule

// File: tb/test_irq_resolver.sv
`timescale 1ns/1ps
module test_irq_resolver;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] lines = '0, en = '0, base = '0;
  logic       aeoi = 1'b1, smm = 1'b0, ens = 1'b0, esp = 1'b0, rdy = 1'b0;
  logic [2:0] elvl = '0;
  logic       valid;
  logic [7:0] vector, req, isr;

  int nchk = 0;
  int nerr = 0;

  logic [7:0] m_req = '0, m_isr = '0, m_prev = '0;

  always #4 clk = ~clk;

  irq_resolver i_irq_resolver (
    .clk          (clk),
    .rst          (rst),
    .irq_lines    (lines),
    .irq_enable   (en),
    .vec_base     (base),
    .auto_eoi     (aeoi),
    .special_mask (smm),
    .eoi_nonspec  (ens),
    .eoi_spec     (esp),
    .eoi_level    (elvl),
    .irq_valid    (valid),
    .irq_ready    (rdy),
    .irq_vector   (vector),
    .pending_bits (req),
    .service_bits (isr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void m_eval(output logic v, output logic [2:0] ix);
    logic [7:0] live;
    logic [7:0] eff;
    logic found;
    logic blk;
    live  = m_req & en;
    found = 1'b0;
    ix    = '0;
    for (int i = 0; i < 8; i++)
      if (!found && live[i]) begin found = 1'b1; ix = 3'(i); end
    eff = smm ? (m_isr & en) : m_isr;
    blk = 1'b0;
    for (int j = 0; j < 8; j++)
      if (j <= int'(ix) && eff[j]) blk = 1'b1;
    v = found && !blk;
  endfunction

  // check outputs against the model, clock once, advance the model
  task automatic step(input string tag);
    logic       ev;
    logic [2:0] ei;
    logic [7:0] g;
    logic [7:0] clr;
    #1;
    m_eval(ev, ei);
    chk("R2", {24'd0, req}, {24'd0, m_req});
    chk("R7", {24'd0, isr}, {24'd0, m_isr});
    chk(tag, {31'd0, valid}, {31'd0, ev});
    if (ev) chk("R5", {24'd0, vector}, {24'd0, base | {5'd0, ei}});
    @(posedge clk);
    g   = (ev && rdy) ? (8'd1 << ei) : 8'd0;
    clr = (ens ? (m_isr & (~m_isr + 8'd1)) : 8'd0) | (esp ? (8'd1 << elvl) : 8'd0);
    m_req  = (m_req | (lines & ~m_prev)) & lines & ~g;
    m_prev = lines;
    m_isr  = (m_isr & ~clr) | (aeoi ? 8'd0 : g);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; lines = '0; rdy = 1'b0; ens = 1'b0; esp = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_req = '0; m_isr = '0; m_prev = '0;
    #1;
    chk("R1", {24'd0, req}, 32'd0);
    chk("R1", {24'd0, isr}, 32'd0);
    chk("R1", {31'd0, valid}, 32'd0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    do_reset();

    // sweep every request pattern under several masks (R4, R5)
    aeoi = 1'b1;
    for (int m = 0; m < 4; m++) begin
      en = (m == 0) ? 8'hFF : (m == 1) ? 8'h5A : (m == 2) ? 8'hF0 : 8'h81;
      base = 8'h08 << m;
      for (int p = 0; p < 256; p++) begin
        lines = 8'(p);
        step("R4");
        step("R4");
        lines = '0;
        step("R4");
      end
    end

    // held line does not re-request (R2)
    do_reset();
    en = 8'hFF; base = 8'h20; lines = 8'h04;
    step("R2");
    chk("R2", {24'd0, req}, 32'h04);
    rdy = 1'b1; step("R6");
    rdy = 1'b0; step("R2");
    chk("R2", {24'd0, req}, 32'h00);
    lines = '0; step("R2");

    // a dropped line loses its request (R3)
    en = 8'h00; lines = 8'h08; step("R4");
    chk("R3", {24'd0, req}, 32'h08);
    chk("R4", {31'd0, valid}, 32'd0);
    lines = '0; step("R3");
    chk("R3", {24'd0, req}, 32'h00);

    // ready without valid, then back-pressure (R6)
    lines = 8'h10; rdy = 1'b1; step("R6"); step("R6");
    chk("R6", {24'd0, req}, 32'h10);
    chk("R6", {31'd0, valid}, 32'd0);
    rdy = 1'b0; en = 8'hFF; base = 8'h48;
    step("R6"); step("R6");
    chk("R6", {31'd0, valid}, 32'd1);
    chk("R5", {24'd0, vector}, 32'h4C);
    rdy = 1'b1; step("R6");
    rdy = 1'b0; #1;
    chk("R6", {24'd0, req}, 32'h00);
    lines = '0; step("R6");

    // in-service tracking, blocking and both EOI forms (R7, R8, R10, R11)
    aeoi = 1'b0; base = 8'h40;
    lines = 8'h20; step("R7");
    rdy = 1'b1; step("R7");
    rdy = 1'b0; #1;
    chk("R7", {24'd0, isr}, 32'h20);
    lines = 8'h24; step("R8");
    rdy = 1'b1; step("R8");
    rdy = 1'b0; #1;
    chk("R7", {24'd0, isr}, 32'h24);
    lines = 8'hA4; step("R8");
    chk("R8", {31'd0, valid}, 32'd0);
    ens = 1'b1; step("R10");
    ens = 1'b0; #1;
    chk("R10", {24'd0, isr}, 32'h20);
    chk("R8", {31'd0, valid}, 32'd0);
    esp = 1'b1; elvl = 3'd5; step("R11");
    esp = 1'b0; #1;
    chk("R11", {24'd0, isr}, 32'h00);
    chk("R8", {31'd0, valid}, 32'd1);
    chk("R8", {24'd0, vector}, 32'h47);
    rdy = 1'b1; step("R8");
    rdy = 1'b0; lines = '0; step("R8");
    esp = 1'b1; elvl = 3'd7; step("R11");
    esp = 1'b0; step("R11");

    // special mask mode (R9)
    lines = 8'h02; step("R9");
    rdy = 1'b1; step("R9");
    rdy = 1'b0; en = 8'hFD; lines = 8'h42; step("R9");
    #1;
    chk("R9", {31'd0, valid}, 32'd0);
    smm = 1'b1; #1;
    chk("R9", {31'd0, valid}, 32'd1);
    chk("R9", {24'd0, vector}, 32'h46);
    step("R9");
    smm = 1'b0; esp = 1'b1; elvl = 3'd1; lines = '0; step("R11");
    esp = 1'b0; step("R11");

    // long pseudo-random interleaving against the model (R8)
    do_reset();
    en = 8'hFF; base = 8'h80;
    for (int k = 0; k < 5000; k++) begin
      if ($urandom % 3 == 0) lines = lines ^ (8'd1 << ($urandom % 8));
      if ($urandom % 40 == 0) en = 8'($urandom);
      if ($urandom % 60 == 0) aeoi = ~aeoi;
      if ($urandom % 50 == 0) smm = ~smm;
      rdy  = ($urandom % 3 == 0);
      ens  = ($urandom % 6 == 0);
      esp  = ($urandom % 7 == 0);
      elvl = 3'($urandom);
      step("R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule